// File: doc/BRIEF.md
# Queued Command Completion Tracker

This block lives on the host side of a storage controller that keeps many commands in flight on a queued-command link. It records which command tags the host has handed to the device. It takes in the completion bitmasks that the device sends on its own initiative, with no handshake in reply. Completed tags are folded into a host-visible done register. A single level-sensitive interrupt then covers every completion that builds up before the host services it, so a burst of completions costs the host one interrupt rather than one per command.

A tag enters the in-flight set only when it is issued with one of the two queued-transfer opcodes. A completion message may name several tags at once, and messages may follow each other on consecutive cycles or land while earlier results are still unserviced. The host clears done bits with a write-one-to-clear mask. Protocol violations raise a sticky fault flag: a completion for a tag that is not in flight, or an issue of a tag that is already in flight.

Top module: `qct_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, `inflight`, `done` and `fault` are all zero after that edge, and `irq` is low.
- R2: `issue_valid` with `issue_op` equal to 8'h60 (queued read) or 8'h61 (queued write), for a tag `n` that is not in flight, sets bit `n` of `inflight` after the next rising edge. Any other opcode has no effect on `inflight`, `done` or `fault`.
- R3: With `cpl_valid` high, every bit of `cpl_mask` whose tag is in flight is cleared in `inflight` and set in `done` at the same edge. One message may retire several tags.
- R4: Completion messages on consecutive cycles, including a message that arrives while earlier done bits are still set, are OR-merged into `done` with no bit lost.
- R5: `irq` is high in every cycle in which any bit of `done` is set, and low when `done` is zero. Many completions share one assertion.
- R6: With `ack_valid` high, each `done` bit whose `ack_mask` bit is 1 is cleared at the next edge. A bit that a completion sets in the same cycle stays set, because the completion wins.
- R7: A `cpl_mask` bit for a tag that is not in flight sets `fault` and is otherwise ignored. It changes neither `inflight` nor `done` for that tag. Valid bits in the same message are still accepted.
- R8: Issuing a queued opcode for a tag that is already in flight sets `fault` and leaves `inflight` unchanged. The in-flight check uses the register value before the edge.
- R9: `fault` is sticky. Once set, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Command issue strobe |
| issue_op | input | 8 | Opcode of the issued command |
| issue_tag | input | 5 | Tag of the issued command |
| cpl_valid | input | 1 | Completion message strobe |
| cpl_mask | input | 32 | Tags reported complete by the device |
| ack_valid | input | 1 | Host acknowledge write strobe |
| ack_mask | input | 32 | Write-one-to-clear mask for `done` |
| inflight | output | 32 | Tags currently outstanding |
| done | output | 32 | Accumulated completed tags awaiting the host |
| irq | output | 1 | Aggregated level interrupt |
| fault | output | 1 | Sticky protocol-violation flag |

## Verification
The bench sends completions on back-to-back cycles while older done bits are still pending. A tracker that overwrote `done` instead of merging it would drop the earlier tags. It also clears a tag and completes the same tag in a single cycle. A design that let the acknowledge win would lose that completion, and `irq` would fall with work still waiting. Stray completion bits and duplicate issues are also applied. A wrong design would either corrupt `inflight` or `done` there, or fail to raise `fault`. A non-queued opcode is issued as well; a design that decoded only the tag would mark that tag outstanding.

// File: rtl/qct_pkg.sv
package qct_pkg;

    localparam int NUM_TAGS = 32;
    localparam int TAG_W    = $clog2(NUM_TAGS);
    localparam int OP_W     = 8;

    typedef enum logic [OP_W-1:0] {
        OP_Q_READ  = 8'h60,
        OP_Q_WRITE = 8'h61
    } queued_op_e;

    typedef logic [NUM_TAGS-1:0] tag_mask_t;

    typedef struct packed {
        logic             valid;
        logic [OP_W-1:0]  op;
        logic [TAG_W-1:0] tag;
    } issue_req_t;

    typedef struct packed {
        tag_mask_t accepted;
        logic      stray;
    } cpl_result_t;

    function automatic logic is_queued_op(input logic [OP_W-1:0] op);
        return (op == OP_Q_READ) || (op == OP_Q_WRITE);
    endfunction

endpackage

// File: rtl/qct_issue_dec.sv
module qct_issue_dec
    import qct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  issue_req_t req,
    input  tag_mask_t  inflight_q,
    output tag_mask_t  set_mask,
    output logic       dup_fault
);
    tag_mask_t onehot;
    logic      queued;

    assign queued = req.valid && is_queued_op(req.op);

    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_dec
        assign onehot[i] = queued && (req.tag == TAG_W'(i));
    end

    assign dup_fault = |(onehot & inflight_q);
    assign set_mask  = dup_fault ? '0 : onehot;

    // R2: a non-queued opcode never contributes a bit
    p_nonqueued_r2: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !is_queued_op(req.op)) |-> (set_mask == '0));

    // R8: a duplicate issue never adds a bit
    p_dup_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        dup_fault |-> (set_mask == '0));

endmodule

// File: rtl/qct_cpl_merge.sv
module qct_cpl_merge
    import qct_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpl_valid,
    input  tag_mask_t   cpl_mask,
    input  tag_mask_t   inflight_q,
    output cpl_result_t res
);
    tag_mask_t gated;

    assign gated        = cpl_valid ? cpl_mask : '0;
    assign res.accepted = gated & inflight_q;
    assign res.stray    = |(gated & ~inflight_q);

    // R7: only in-flight tags are ever accepted
    p_accept_subset_r7: assert property (@(posedge clk) disable iff (rst)
        ((res.accepted & ~inflight_q) == '0));

    // R3: with no strobe nothing is accepted
    p_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !cpl_valid |-> (res.accepted == '0 && !res.stray));

endmodule

// File: rtl/qct_fault_flag.sv
module qct_fault_flag (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (raise) flag <= 1'b1;
    end

    // R9: once set the flag holds until reset
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag);

    p_raise_r7: assert property (@(posedge clk) disable iff (rst)
        raise |=> flag);

endmodule

// File: rtl/qct_tracker.sv
module qct_tracker
    import qct_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  logic [OP_W-1:0]     issue_op,
    input  logic [TAG_W-1:0]    issue_tag,
    input  logic                cpl_valid,
    input  logic [NUM_TAGS-1:0] cpl_mask,
    input  logic                ack_valid,
    input  logic [NUM_TAGS-1:0] ack_mask,
    output logic [NUM_TAGS-1:0] inflight,
    output logic [NUM_TAGS-1:0] done,
    output logic                irq,
    output logic                fault
);
    tag_mask_t   inflight_q, done_q, set_mask, clr_mask;
    issue_req_t  req;
    cpl_result_t cres;
    logic        dup_fault;

    assign req = '{valid: issue_valid, op: issue_op, tag: issue_tag};

    qct_issue_dec u_dec (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .inflight_q (inflight_q),
        .set_mask   (set_mask),
        .dup_fault  (dup_fault)
    );

    qct_cpl_merge u_merge (
        .clk        (clk),
        .rst        (rst),
        .cpl_valid  (cpl_valid),
        .cpl_mask   (cpl_mask),
        .inflight_q (inflight_q),
        .res        (cres)
    );

    qct_fault_flag u_fault (
        .clk   (clk),
        .rst   (rst),
        .raise (dup_fault || cres.stray),
        .flag  (fault)
    );

    assign clr_mask = ack_valid ? ack_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= '0;
            done_q     <= '0;
        end else begin
            inflight_q <= (inflight_q & ~cres.accepted) | set_mask;
            done_q     <= (done_q & ~clr_mask) | cres.accepted;
        end
    end

    assign inflight = inflight_q;
    assign done     = done_q;
    assign irq      = |done_q;

    // R3: accepted tags leave the in-flight set
    p_cpl_clears_r3: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> ((inflight_q & $past(cpl_mask & inflight_q)) == '0));

    // R6: accepted tags show up as done even under an acknowledge
    p_cpl_wins_r6: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> ((done_q & $past(cpl_mask & inflight_q))
                       == $past(cpl_mask & inflight_q)));

    // R5: without an acknowledge the interrupt cannot drop
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack_valid) |=> irq);

    // R8: duplicate issue with no completion leaves in-flight unchanged
    p_dup_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (dup_fault && !cpl_valid) |=> $stable(inflight_q));

endmodule

// File: tb/qct_tracker_bench.sv
module qct_tracker_bench;
    import qct_pkg::*;

    typedef struct {
        logic [31:0] inflight;
        logic [31:0] done;
        logic        irq;
        logic        fault;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [7:0]  issue_op = 8'h00;
    logic [4:0]  issue_tag = 5'd0;
    logic        cpl_valid = 1'b0;
    logic [31:0] cpl_mask = '0;
    logic        ack_valid = 1'b0;
    logic [31:0] ack_mask = '0;
    logic [31:0] inflight, done;
    logic        irq, fault;

    logic [31:0] m_out = '0, m_done = '0;
    logic        m_fault = 1'b0;
    exp_t        sb[$];
    int          checks = 0, errors = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    qct_tracker u_qct_tracker (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_op(issue_op), .issue_tag(issue_tag),
        .cpl_valid(cpl_valid), .cpl_mask(cpl_mask),
        .ack_valid(ack_valid), .ack_mask(ack_mask),
        .inflight(inflight), .done(done), .irq(irq), .fault(fault)
    );

    task automatic step(input logic r, input logic iv, input logic [7:0] op,
                        input logic [4:0] tg, input logic cv, input logic [31:0] cm,
                        input logic av, input logic [31:0] am, input string tag);
        logic [31:0] setb, good, bad;
        logic        dup;
        exp_t        e;
        @(negedge clk);
        rst = r; issue_valid = iv; issue_op = op; issue_tag = tg;
        cpl_valid = cv; cpl_mask = cm; ack_valid = av; ack_mask = am;
        if (r) begin
            m_out = '0; m_done = '0; m_fault = 1'b0;
        end else begin
            setb = (iv && (op == 8'h60 || op == 8'h61)) ? (32'd1 << tg) : '0;
            dup  = (setb & m_out) != 0;
            good = cv ? (cm & m_out) : '0;
            bad  = cv ? (cm & ~m_out) : '0;
            m_fault = m_fault | dup | (bad != 0);
            m_out   = (m_out & ~good) | (dup ? 32'd0 : setb);
            m_done  = (m_done & ~(av ? am : 32'd0)) | good;
        end
        e.inflight = m_out; e.done = m_done; e.irq = (m_done != 0);
        e.fault = m_fault; e.req = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 8'h00, 0, 0, '0, 0, '0, tag);
    endtask

    task automatic issue(input logic [7:0] op, input logic [4:0] tg, input string tag);
        step(0, 1, op, tg, 0, '0, 0, '0, tag);
    endtask

    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            #2;
            e = sb.pop_front();
            checks++;
            if (inflight !== e.inflight || done !== e.done ||
                irq !== e.irq || fault !== e.fault) begin
                errors++;
                $display("FAIL %s: got inflight=%h done=%h irq=%b fault=%b exp inflight=%h done=%h irq=%b fault=%b",
                         e.req, inflight, done, irq, fault,
                         e.inflight, e.done, e.irq, e.fault);
            end
        end
    end

    initial begin
        step(1, 0, 8'h00, 0, 0, '0, 0, '0, "R1");
        step(1, 1, 8'h60, 3, 1, 32'hFFFF_FFFF, 0, '0, "R1");
        issue(8'h60, 0,  "R2");
        issue(8'h61, 31, "R2");
        issue(8'h60, 7,  "R2");
        issue(8'h61, 12, "R2");
        issue(8'h60, 3,  "R2");
        issue(8'h25, 5,  "R2");
        // one message retires two tags
        step(0, 0, 8'h00, 0, 1, 32'h0000_0081, 0, '0, "R3");
        // back-to-back messages merged with pending bits
        step(0, 0, 8'h00, 0, 1, 32'h8000_0000, 0, '0, "R4");
        step(0, 0, 8'h00, 0, 1, 32'h0000_1000, 0, '0, "R4");
        idle("R5");
        // ack tag 0 while tag 3 completes
        step(0, 0, 8'h00, 0, 1, 32'h0000_0008, 1, 32'h0000_0001, "R6");
        issue(8'h60, 0, "R2");
        // same tag acknowledged and completed in one cycle
        step(0, 0, 8'h00, 0, 1, 32'h0000_0001, 1, 32'h0000_0001, "R6");
        step(0, 0, 8'h00, 0, 0, '0, 1, 32'hFFFF_FFFF, "R5");
        // stray completion bit for tag 9 plus valid tag 0 reissued
        issue(8'h61, 0, "R2");
        step(0, 0, 8'h00, 0, 1, 32'h0000_0201, 0, '0, "R7");
        idle("R9");
        issue(8'h60, 2, "R9");
        step(1, 0, 8'h00, 0, 0, '0, 0, '0, "R1");
        issue(8'h60, 4, "R2");
        issue(8'h61, 4, "R8");
        idle("R9");
        idle("R9");
        repeat (3) @(posedge clk);
        #3;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule